// File: doc/BRIEF.md
# Program/Erase Status Flag Generator

An embedded program or erase can take a long time. While it runs, a host read must not return array contents. It must return a status word that shows whether the operation is still running, how it is going, and whether it has failed. This block builds that status word from events reported by the operation sequencer. It also drives an active-low ready/busy line, which the board wires as an open-drain signal.

Status word bits:

- **Bit 7 (data-polling bit):** during a program it reads as the inverse of the bit being written. During an erase it reads 0.
- **Bit 6 (toggle bit):** it flips on every status read.
- **Bit 5 (timeout bit):** it latches when the sequencer reports a timeout. It holds until a read/reset command arrives.
- **Bit 3 (erase window bit):** it shows whether the window for adding sectors to an erase is still open.

When the operation completes without a timeout, reads return array data again at once. Array data carries the written value, so a polling host sees bit 7 match its data.

Reads are counted on the rising edge of a read strobe. Each read captures one word into a holding register, which stays stable until the next read.

Top module: `pe_status_gen`

## Requirements
- R1: While reset is asserted, and after it, `ry_by` is 1 (ready) and `rd_data` is all zeros.
- R2: With no operation in progress, a read returns `array_data` as sampled on the read-strobe rising edge.
- R3: During a program, bit 7 of a status read is the inverse of `wr_data[7]` as latched on `op_start`. Later changes of `wr_data` have no effect.
- R4: During an erase, bit 7 of a status read is 0.
- R5: Bit 6 of the status word is 0 on the first status read after `op_start`. It inverts on each following status read.
- R6: `time_over` during an operation sets bit 5 and keeps the block in status mode, with `ry_by` low, even after `op_done`. `time_over` with no operation has no effect.
- R7: Bit 3 equals `erase_win_open` during an erase and is 0 during a program. Status bits 4, 2, 1, 0 and all bits above 7 are always 0.
- R8: `ry_by` goes low in the cycle after an accepted `op_start` and stays low until the operation ends.
- R9: `op_done` without a timeout ends the operation. `ry_by` returns to 1, and reads return `array_data`, so the toggle bit stops appearing.
- R10: `clr_cmd` ends a timed-out operation, with `ry_by` 1 and array reads resumed. `clr_cmd` has no effect on an operation that has not timed out.
- R11: `op_start` is ignored while in status mode. The type of operation and the latched bit 7 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Sequencer starts an operation (one-cycle pulse) |
| op_is_erase | input | 1 | Operation type at `op_start`: 1 erase, 0 program |
| op_done | input | 1 | Sequencer reports completion (pulse) |
| wr_data | input | DW | Data being programmed |
| time_over | input | 1 | Sequencer timeout flag |
| erase_win_open | input | 1 | Sector-add window for an erase is still open |
| clr_cmd | input | 1 | Read/reset command decoded |
| rd_strobe | input | 1 | Host read strobe; each rising edge is one read |
| array_data | input | DW | Array read data |
| rd_data | output | DW | Word returned to the host |
| ry_by | output | 1 | Ready (1) / busy (0) |

## Verification
The assertions assume the following about the inputs:

- `op_start`, `op_done` and `time_over` are one-cycle pulses.
- The sequencer raises `op_done` only after a start.
- `rd_strobe` stays low for at least one clock between reads, so that each read gives exactly one rising edge.

The stimulus drives every event at the falling clock edge as a single-cycle pulse. It separates consecutive reads with a low cycle. It also provokes the cases that a real sequencer would not produce, such as a second start, a clear command during a busy phase, and a timeout while idle. These cases check that the block ignores them.

// File: rtl/pe_status_gen.sv
module pe_status_gen #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic          op_is_erase,
  input  logic          op_done,
  input  logic [DW-1:0] wr_data,
  input  logic          time_over,
  input  logic          erase_win_open,
  input  logic          clr_cmd,
  input  logic          rd_strobe,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          ry_by
);
  localparam int POLL_B = 7;
  localparam int TOG_B  = 6;
  localparam int FAIL_B = 5;
  localparam int WIN_B  = 3;

  logic busy_q, erase_q, d7_q, tog_q, fail_q, rd_q;
  logic [DW-1:0] stat_word;

  wire stat_mode = busy_q | fail_q;
  wire rd_rise   = rd_strobe & ~rd_q;
  wire start_ok  = op_start & ~stat_mode;

  assign ry_by = ~stat_mode;

  always_comb begin
    stat_word         = '0;
    stat_word[POLL_B] = ~erase_q & ~d7_q;
    stat_word[TOG_B]  = tog_q;
    stat_word[FAIL_B] = fail_q;
    stat_word[WIN_B]  = erase_q & erase_win_open;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      d7_q    <= 1'b0;
      tog_q   <= 1'b0;
      fail_q  <= 1'b0;
      rd_q    <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_q <= rd_strobe;
      if (rd_rise) rd_data <= stat_mode ? stat_word : array_data;
      if (start_ok) begin
        busy_q  <= 1'b1;
        erase_q <= op_is_erase;
        d7_q    <= wr_data[POLL_B];
        tog_q   <= 1'b0;
        fail_q  <= 1'b0;
      end else begin
        if (busy_q && op_done) busy_q <= 1'b0;
        if (busy_q && time_over) fail_q <= 1'b1;
        if (fail_q && clr_cmd) begin
          fail_q <= 1'b0;
          busy_q <= 1'b0;
        end
        if (rd_rise && stat_mode) tog_q <= ~tog_q;
      end
    end
  end

  // R2
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && !stat_mode) |=> rd_data == $past(array_data));
  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && stat_mode) |=> tog_q != $past(tog_q));
  // R6
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr_cmd) |=> (fail_q && !ry_by));
  // R8
  busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && ry_by) |=> !ry_by);
  // R9
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && busy_q && !fail_q && !time_over) |=> ry_by);
  // R11
  restart_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !ry_by) |=> $stable(erase_q) && $stable(d7_q));
endmodule

// File: tb/tb_pe_status_gen.sv
module tb_pe_status_gen;
  localparam int DW = 16;
  logic clk = 0, rst_n = 0;
  logic op_start = 0, op_is_erase = 0, op_done = 0, time_over = 0;
  logic erase_win_open = 0, clr_cmd = 0, rd_strobe = 0;
  logic [DW-1:0] wr_data = '0, array_data = '0;
  logic [DW-1:0] rd_data;
  logic ry_by;

  int errors = 0, checks = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  event sample_ev;

  always #2 clk = ~clk;

  pe_status_gen #(.DW(DW)) dut (.*);

  function automatic logic [DW-1:0] stat(input logic er, input logic d7,
      input logic tg, input logic fl, input logic win);
    logic [DW-1:0] s = '0;
    s[7] = er ? 1'b0 : ~d7;
    s[6] = tg;
    s[5] = fl;
    s[3] = er & win;
    return s;
  endfunction

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [DW-1:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk) rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
    -> sample_ev;
    #0;
  endtask

  task automatic pulse_start(input logic er, input logic [DW-1:0] d);
    @(negedge clk) begin op_start = 1; op_is_erase = er; wr_data = d; end
    @(negedge clk) op_start = 0;
  endtask

  task automatic pulse_done;  @(negedge clk) op_done = 1;   @(negedge clk) op_done = 0;   endtask
  task automatic pulse_to;    @(negedge clk) time_over = 1; @(negedge clk) time_over = 0; endtask
  task automatic pulse_clr;   @(negedge clk) clr_cmd = 1;   @(negedge clk) clr_cmd = 0;   endtask

  always @(sample_ev) begin
    logic [DW-1:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
    end
  end

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check1("R1 reset ry_by", ry_by, 1'b1);
    checks++;
    if (rd_data !== '0) begin
      errors++;
      $display("FAIL R1: rd_data=%h expected 0", rd_data);
    end
    @(negedge clk) rst_n = 1;
    array_data = 16'h1234;
    do_read(16'h1234, "R2 idle read");

    // program with bit7=1
    pulse_start(1'b0, 16'h0080);
    check1("R8 busy after start", ry_by, 1'b0);
    wr_data = 16'h0000; array_data = 16'hFFFF; erase_win_open = 1;
    do_read(stat(0, 1, 0, 0, 1), "R3/R5/R7 first program read");
    do_read(stat(0, 1, 1, 0, 1), "R5 toggle second read");
    do_read(stat(0, 1, 0, 0, 1), "R5 toggle third read");
    pulse_done;
    check1("R9 ready after done", ry_by, 1'b1);
    array_data = 16'hABCD;
    do_read(16'hABCD, "R9 array after done");

    // program with bit7=0, ignored restart and clear
    pulse_start(1'b0, 16'h0000);
    do_read(stat(0, 0, 0, 0, 1), "R3 program bit7 inverted");
    pulse_start(1'b1, 16'h0080);
    do_read(stat(0, 0, 1, 0, 1), "R11 restart ignored");
    pulse_clr;
    check1("R10 clr ignored while busy", ry_by, 1'b0);
    do_read(stat(0, 0, 0, 0, 1), "R10 status after ignored clr");
    pulse_done;

    // erase with timeout
    pulse_start(1'b1, 16'h0000);
    do_read(stat(1, 0, 0, 0, 1), "R4/R7 erase window open");
    erase_win_open = 0;
    do_read(stat(1, 0, 1, 0, 0), "R4/R7 erase window closed");
    pulse_to;
    do_read(stat(1, 0, 0, 1, 0), "R6 timeout bit set");
    pulse_done;
    check1("R6 still busy after done", ry_by, 1'b0);
    do_read(stat(1, 0, 1, 1, 0), "R6 timeout held after done");
    pulse_clr;
    check1("R10 ready after clr", ry_by, 1'b1);
    array_data = 16'h5A5A;
    do_read(16'h5A5A, "R10 array after clr");

    // timeout while idle
    pulse_to;
    check1("R6 idle timeout ready", ry_by, 1'b1);
    do_read(16'h5A5A, "R6 idle timeout ignored");

    // reset during an operation
    pulse_start(1'b0, 16'h0080);
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    check1("R1 ready during reset", ry_by, 1'b1);
    @(negedge clk) rst_n = 1;
    check1("R1 ready after reset", ry_by, 1'b1);

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule